// File: doc/BRIEF.md
# Overflow-Driven Trace Sampler

This block is a per-thread sampling engine that runs in one of two modes. A 32-bit sampling counter starts at a programmable reload value. It advances on a selectable tick source, which is either every clock or one or two chosen event strobes. It overflows when it steps past all-ones. Alongside it, two 32-bit event counters count the two selected strobes.

In trace mode, each overflow captures the program counter of that cycle together with both event counts. It then emits a 16-byte record as two 64-bit write beats into a circular buffer, whose base address and size come from the control inputs. In accumulation mode, each overflow posts the two counts as one beat to a fixed slot at the buffer base. In both modes the sampling counter reloads itself. No interrupt is raised for any sample. When the buffer end is reached, the write pointer silently returns to the base.

Samples that arrive while a previous write is still pending are dropped and tallied in a saturating counter. Clearing the enable bit freezes counting at once. Setting the enable bit again restarts the block from a clean interval.

Top module: `smp_trace_engine`

## Requirements
- R1: While reset is asserted and after it is released, `wr_valid_o` is 0 and `lost_o` is 0.
- R2: The control word is numbered MSB-first: bit 0 (`ctl_i[63]`) enables the block, bit 1 (`ctl_i[62]`) picks the mode (1 = trace, 0 = accumulation), and bits 8..50 (`ctl_i[55:13]`) hold the base byte address divided by 8192. With enable at 0, nothing counts and no write is issued.
- R3: The configuration word is numbered MSB-first. The tick source is `cfg_i[63:62]`, where 0 = every clock, 1 = event A, 2 = event B and 3 = A or B. The reload value is `cfg_i[61:30]`, event A index is `cfg_i[29:23]`, event B index is `cfg_i[22:16]`, and the size code is `cfg_i[15:13]`. Event A and B counters add 1 in each enabled cycle in which their indexed strobe is high.
- R4: The sampling counter is loaded with the reload value when the block is enabled. It adds 1 on each tick. A tick that finds it at 0xFFFFFFFF is an overflow and loads the reload value instead.
- R5: In trace mode, an overflow with no write pending makes the first beat appear on the next cycle. The first beat carries the address base+pointer and the `pc_i` value of the overflow cycle. The second beat carries the address plus 8 and the data {count A, count B}, with count A in bits 63:32. Both counts include the overflow cycle's strobes.
- R6: The trace pointer advances by 16 at each captured sample. It returns to 0 when it would reach 4096 << size code.
- R7: In accumulation mode, an overflow with no write pending issues a single beat at the base address carrying {count A, count B}, and leaves the pointer unchanged.
- R8: A beat is transferred on a cycle with `wr_valid_o` and `wr_ready_i` both high. Until then, its address and data hold steady.
- R9: An overflow in a cycle where a write is still pending, including the cycle in which the last beat is accepted, is dropped. It adds 1 to `lost_o`, which saturates at all-ones.
- R10: Clearing enable stops all counting at once, while a record already started still completes. Re-enabling resets the pointer, both event counts and `lost_o`, and reloads the sampling counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_i | input | 64 | Enable, mode and buffer base control word |
| cfg_i | input | 64 | Tick source, reload, event indices and buffer size |
| evt_i | input | NUM_EVT | Per-cycle event strobes |
| pc_i | input | 64 | Current program counter |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted by memory side |
| wr_addr_o | output | 56 | Byte address of the beat |
| wr_data_o | output | 64 | Beat data |
| lost_o | output | LOST_W | Saturating count of dropped samples |

## Verification
The hardest state to reach from the ports is a full lost-sample counter. To fill it, samples must keep overflowing while a record stays stalled for hundreds of cycles. The stimulus loads a reload value of all-ones with the every-clock tick source, which makes every enabled cycle an overflow, and then holds the ready input low for 300 cycles before releasing it. Wrap-around of the pointer is reached by running a short interval against the smallest buffer for more than 256 records. The drop on the exact cycle that the last beat is accepted arises from random ready patterns played against a reference model that is compared on every clock.

// File: rtl/smp_pkg.sv
package smp_pkg;

    // Word widths
    localparam int WORD_W  = 64;
    localparam int CNT_W   = 32;
    localparam int SEL_W   = 7;
    localparam int SZ_W    = 3;
    localparam int ADDR_W  = 56;

    // Buffer geometry
    localparam int MIN_BUF_LOG2 = 12;
    localparam int REC_BYTES    = 16;
    localparam int BEAT_BYTES   = 8;
    localparam int PTR_W        = MIN_BUF_LOG2 + (1 << SZ_W) - 1;

    // Control word fields (MSB-first numbering mapped onto [63:0])
    localparam int CTL_EN_IX    = 63;
    localparam int CTL_MODE_IX  = 62;
    localparam int CTL_BASE_HI  = 55;
    localparam int CTL_BASE_LO  = 13;

    // Configuration word fields
    localparam int CFG_SRC_HI   = 63;
    localparam int CFG_SRC_LO   = 62;
    localparam int CFG_RLD_HI   = 61;
    localparam int CFG_RLD_LO   = 30;
    localparam int CFG_EVA_HI   = 29;
    localparam int CFG_EVA_LO   = 23;
    localparam int CFG_EVB_HI   = 22;
    localparam int CFG_EVB_LO   = 16;
    localparam int CFG_SZ_HI    = 15;
    localparam int CFG_SZ_LO    = 13;

    typedef enum logic [1:0] {
        SRC_CLOCK  = 2'd0,
        SRC_EVA    = 2'd1,
        SRC_EVB    = 2'd2,
        SRC_EITHER = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_PC   = 2'd1,
        WR_CNT  = 2'd2,
        WR_ACC  = 2'd3
    } wr_state_e;

endpackage

// File: rtl/smp_event_select.sv
module smp_event_select
    import smp_pkg::*;
#(
    parameter int NUM_EVT = 128,
    parameter int IDX_W   = SEL_W
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [IDX_W-1:0]   idx_a_i,
    input  logic [IDX_W-1:0]   idx_b_i,
    input  logic [1:0]         src_i,
    output logic               hit_a_o,
    output logic               hit_b_o,
    output logic               tick_o
);

    localparam int SPAN = 1 << IDX_W;

    logic [SPAN-1:0] strobes;

    // Fit the strobe vector to the index range
    generate
        if (NUM_EVT >= SPAN) begin : g_trim
            assign strobes = evt_i[SPAN-1:0];
        end else begin : g_pad
            assign strobes = {{(SPAN - NUM_EVT){1'b0}}, evt_i};
        end
    endgenerate

    always_comb begin
        hit_a_o = strobes[idx_a_i];
        hit_b_o = strobes[idx_b_i];
        unique case (tick_src_e'(src_i))
            SRC_CLOCK:  tick_o = 1'b1;
            SRC_EVA:    tick_o = hit_a_o;
            SRC_EVB:    tick_o = hit_b_o;
            SRC_EITHER: tick_o = hit_a_o | hit_b_o;
            default:    tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/smp_sample_counter.sv
module smp_sample_counter
    import smp_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          hit_a_i,
    input  logic          hit_b_i,
    input  logic [CW-1:0] reload_i,
    output logic          ovf_o,
    output logic [CW-1:0] smp_o,
    output logic [CW-1:0] cnt_a_o,
    output logic [CW-1:0] cnt_b_o
);

    localparam logic [CW-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CW-1:0] smp;
        logic [CW-1:0] cnt_a;
        logic [CW-1:0] cnt_b;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        ovf_o = 1'b0;
        if (start_i) begin
            s_d.smp   = reload_i;
            s_d.cnt_a = '0;
            s_d.cnt_b = '0;
        end else if (run_i) begin
            s_d.cnt_a = s_q.cnt_a + CW'(hit_a_i);
            s_d.cnt_b = s_q.cnt_b + CW'(hit_b_i);
            if (tick_i) begin
                if (s_q.smp == CNT_TOP) begin
                    ovf_o   = 1'b1;
                    s_d.smp = reload_i;
                end else begin
                    s_d.smp = s_q.smp + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Counts handed to the snapshot include this cycle's strobes
    assign smp_o   = s_q.smp;
    assign cnt_a_o = s_d.cnt_a;
    assign cnt_b_o = s_d.cnt_b;

endmodule

// File: rtl/smp_record_writer.sv
module smp_record_writer
    import smp_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int CW     = CNT_W,
    parameter int DW     = 2 * CW,
    parameter int SZW    = SZ_W,
    parameter int PW     = PTR_W,
    parameter int LOST_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              ovf_i,
    input  logic              trace_i,
    input  logic [AW-1:0]     base_i,
    input  logic [SZW-1:0]    size_i,
    input  logic [DW-1:0]     pc_i,
    input  logic [CW-1:0]     cnt_a_i,
    input  logic [CW-1:0]     cnt_b_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [AW-1:0]     addr_o,
    output logic [DW-1:0]     data_o,
    output logic              busy_o,
    output logic [LOST_W-1:0] lost_o
);

    localparam logic [LOST_W-1:0] LOST_TOP = '1;

    typedef struct packed {
        wr_state_e         state;
        logic [PW-1:0]     ptr;
        logic [LOST_W-1:0] lost;
        logic [AW-1:0]     rec_addr;
        logic [DW-1:0]     rec_pc;
        logic [DW-1:0]     rec_cnt;
    } wr_t;

    wr_t s_d, s_q;

    logic          busy;
    logic          take;
    logic          accept;
    logic [PW:0]   ptr_inc;
    logic [PW:0]   ptr_lim;
    logic [PW-1:0] ptr_next;

    always_comb begin
        busy    = (s_q.state != WR_IDLE);
        take    = ovf_i & ~busy;
        accept  = busy & ready_i;

        // Pointer step with silent wrap at the buffer end
        ptr_inc = {1'b0, s_q.ptr} + (PW + 1)'(REC_BYTES);
        ptr_lim = (PW + 1)'(1) << (MIN_BUF_LOG2 + int'(size_i));
        if (ptr_inc >= ptr_lim) begin
            ptr_next = '0;
        end else begin
            ptr_next = ptr_inc[PW-1:0];
        end

        s_d = s_q;

        // Beat sequencing
        unique case (s_q.state)
            WR_PC:   if (accept) s_d.state = WR_CNT;
            WR_CNT:  if (accept) s_d.state = WR_IDLE;
            WR_ACC:  if (accept) s_d.state = WR_IDLE;
            default: s_d.state = WR_IDLE;
        endcase

        // Snapshot capture
        if (take) begin
            s_d.rec_cnt = {cnt_a_i, cnt_b_i};
            if (trace_i) begin
                s_d.state    = WR_PC;
                s_d.rec_pc   = pc_i;
                s_d.rec_addr = base_i + AW'(s_q.ptr);
                s_d.ptr      = ptr_next;
            end else begin
                s_d.state    = WR_ACC;
                s_d.rec_addr = base_i;
            end
        end

        // Dropped samples
        if (ovf_i && busy && (s_q.lost != LOST_TOP)) begin
            s_d.lost = s_q.lost + LOST_W'(1);
        end

        // Restart clears the pointer and the tally
        if (start_i) begin
            s_d.ptr  = '0;
            s_d.lost = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        valid_o = (s_q.state != WR_IDLE);
        busy_o  = valid_o;
        lost_o  = s_q.lost;
        if (s_q.state == WR_CNT) begin
            addr_o = s_q.rec_addr + AW'(BEAT_BYTES);
        end else begin
            addr_o = s_q.rec_addr;
        end
        if (s_q.state == WR_PC) begin
            data_o = s_q.rec_pc;
        end else begin
            data_o = s_q.rec_cnt;
        end
    end

endmodule

// File: rtl/smp_trace_engine.sv
module smp_trace_engine
    import smp_pkg::*;
#(
    parameter int NUM_EVT = 128,
    parameter int LOST_W  = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [63:0]         ctl_i,
    input  logic [63:0]         cfg_i,
    input  logic [NUM_EVT-1:0]  evt_i,
    input  logic [63:0]         pc_i,
    output logic                wr_valid_o,
    input  logic                wr_ready_i,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [63:0]         wr_data_o,
    output logic [LOST_W-1:0]   lost_o
);

    localparam int BASE_FIELD_W = CTL_BASE_HI - CTL_BASE_LO + 1;
    localparam int BASE_PAD_W   = ADDR_W - BASE_FIELD_W;

    typedef struct packed {
        logic en;
    } top_t;

    top_t s_d, s_q;

    logic              en;
    logic              start;
    logic              run;
    logic              trace_mode;
    logic [ADDR_W-1:0] base;
    logic [1:0]        tick_src;
    logic [CNT_W-1:0]  reload;
    logic [SEL_W-1:0]  idx_a;
    logic [SEL_W-1:0]  idx_b;
    logic [SZ_W-1:0]   size_code;
    logic              hit_a;
    logic              hit_b;
    logic              tick;
    logic              ovf;
    logic              busy;
    logic [CNT_W-1:0]  smp_cnt;
    logic [CNT_W-1:0]  cnt_a;
    logic [CNT_W-1:0]  cnt_b;
    logic              unused_fields;

    // Field decode
    always_comb begin
        en         = ctl_i[CTL_EN_IX];
        trace_mode = ctl_i[CTL_MODE_IX];
        base       = {ctl_i[CTL_BASE_HI:CTL_BASE_LO], {BASE_PAD_W{1'b0}}};
        tick_src   = cfg_i[CFG_SRC_HI:CFG_SRC_LO];
        reload     = cfg_i[CFG_RLD_HI:CFG_RLD_LO];
        idx_a      = cfg_i[CFG_EVA_HI:CFG_EVA_LO];
        idx_b      = cfg_i[CFG_EVB_HI:CFG_EVB_LO];
        size_code  = cfg_i[CFG_SZ_HI:CFG_SZ_LO];
    end

    // Scope and reserved bits have no function here
    assign unused_fields = ^{ctl_i[61:56], ctl_i[12:0], cfg_i[12:0]};

    // Enable edge tracking
    always_comb begin
        s_d.en = en;
        start  = en & ~s_q.en;
        run    = en & s_q.en;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    smp_event_select #(
        .NUM_EVT (NUM_EVT),
        .IDX_W   (SEL_W)
    ) u_sel (
        .evt_i   (evt_i),
        .idx_a_i (idx_a),
        .idx_b_i (idx_b),
        .src_i   (tick_src),
        .hit_a_o (hit_a),
        .hit_b_o (hit_b),
        .tick_o  (tick)
    );

    smp_sample_counter #(
        .CW (CNT_W)
    ) u_ctr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .run_i    (run),
        .tick_i   (tick),
        .hit_a_i  (hit_a),
        .hit_b_i  (hit_b),
        .reload_i (reload),
        .ovf_o    (ovf),
        .smp_o    (smp_cnt),
        .cnt_a_o  (cnt_a),
        .cnt_b_o  (cnt_b)
    );

    smp_record_writer #(
        .AW     (ADDR_W),
        .CW     (CNT_W),
        .DW     (WORD_W),
        .SZW    (SZ_W),
        .PW     (PTR_W),
        .LOST_W (LOST_W)
    ) u_wr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .ovf_i   (ovf),
        .trace_i (trace_mode),
        .base_i  (base),
        .size_i  (size_code),
        .pc_i    (pc_i),
        .cnt_a_i (cnt_a),
        .cnt_b_i (cnt_b),
        .ready_i (wr_ready_i),
        .valid_o (wr_valid_o),
        .addr_o  (wr_addr_o),
        .data_o  (wr_data_o),
        .busy_o  (busy),
        .lost_o  (lost_o)
    );

endmodule

// File: rtl/smp_trace_checker.sv
module smp_trace_checker #(
    parameter int LOST_W = 8,
    parameter int AW     = 56,
    parameter int CW     = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              wr_valid_i,
    input logic              wr_ready_i,
    input logic [AW-1:0]     wr_addr_i,
    input logic [63:0]       wr_data_i,
    input logic [LOST_W-1:0] lost_i,
    input logic              ovf_i,
    input logic              busy_i,
    input logic [CW-1:0]     smp_i,
    input logic [CW-1:0]     reload_i
);

    localparam logic [LOST_W-1:0] LOST_TOP = '1;

    a_r8_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_i && !wr_ready_i |=> wr_valid_i && $stable(wr_addr_i) && $stable(wr_data_i));

    a_r9_drop_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i && busy_i && (lost_i != LOST_TOP) |=> lost_i == LOST_W'($past(lost_i) + 1'b1));

    a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i && busy_i && (lost_i == LOST_TOP) |=> lost_i == LOST_TOP);

    a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i |=> smp_i == $past(reload_i));

    a_r5_sample_issued: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i && !busy_i |=> wr_valid_i);

    a_r10_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i && !busy_i |=> !wr_valid_i);

endmodule

bind smp_trace_engine smp_trace_checker #(
    .LOST_W (LOST_W),
    .AW     (smp_pkg::ADDR_W),
    .CW     (smp_pkg::CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .wr_valid_i (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_i  (wr_addr_o),
    .wr_data_i  (wr_data_o),
    .lost_i     (lost_o),
    .ovf_i      (ovf),
    .busy_i     (busy),
    .smp_i      (smp_cnt),
    .reload_i   (reload)
);

// File: tb/smp_trace_engine_bench.sv
`timescale 1ns/1ps
module smp_trace_engine_bench;

    localparam int NE = 128;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   ctl = '0;
    logic [63:0]   cfg = '0;
    logic [NE-1:0] evt = '0;
    logic [63:0]   pc = '0;
    logic          rdy = 1'b0;
    logic          wr_valid;
    logic [55:0]   wr_addr;
    logic [63:0]   wr_data;
    logic [LW-1:0] lost;

    always #4 clk = ~clk;

    smp_trace_engine #(.NUM_EVT(NE), .LOST_W(LW)) u_smp_trace_engine (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ctl_i      (ctl),
        .cfg_i      (cfg),
        .evt_i      (evt),
        .pc_i       (pc),
        .wr_valid_o (wr_valid),
        .wr_ready_i (rdy),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .lost_o     (lost)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    typedef struct { logic [55:0] a; logic [63:0] d; } beat_t;
    beat_t       q[$];
    bit          m_en = 0;
    logic [31:0] m_smp = 0, m_c1 = 0, m_c2 = 0;
    int          m_ptr = 0;
    int          m_lost = 0;
    string       req = "R1";

    function automatic logic [63:0] mk_ctl(bit en, bit tr, logic [42:0] base);
        logic [63:0] r = '0;
        r[63] = en; r[62] = tr; r[55:13] = base;
        return r;
    endfunction

    function automatic logic [63:0] mk_cfg(logic [1:0] src, logic [31:0] rld,
                                           logic [6:0] ea, logic [6:0] eb, logic [2:0] sz);
        logic [63:0] r = '0;
        r[63:62] = src; r[61:30] = rld; r[29:23] = ea; r[22:16] = eb; r[15:13] = sz;
        return r;
    endfunction

    task automatic chk(bit ok, string r, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // Advance the model over the coming clock edge using the applied inputs
    task automatic model_step();
        bit          busy = (q.size() != 0);
        bit          en = ctl[63];
        bit          h1, h2, tk, ov;
        logic [55:0] base;
        ov = 0;
        if (busy && rdy) void'(q.pop_front());
        if (en && !m_en) begin
            m_smp = cfg[61:30]; m_c1 = 0; m_c2 = 0; m_ptr = 0; m_lost = 0;
        end else if (en) begin
            h1 = evt[cfg[29:23]];
            h2 = evt[cfg[22:16]];
            m_c1 = m_c1 + 32'(h1);
            m_c2 = m_c2 + 32'(h2);
            case (cfg[63:62])
                2'd0: tk = 1;
                2'd1: tk = h1;
                2'd2: tk = h2;
                default: tk = h1 | h2;
            endcase
            if (tk) begin
                if (m_smp == 32'hFFFF_FFFF) begin ov = 1; m_smp = cfg[61:30]; end
                else m_smp = m_smp + 1;
            end
            if (ov) begin
                base = {ctl[55:13], 13'b0};
                if (busy) begin
                    if (m_lost < 255) m_lost++;
                end else if (ctl[62]) begin
                    q.push_back('{base + 56'(m_ptr), pc});
                    q.push_back('{base + 56'(m_ptr) + 56'd8, {m_c1, m_c2}});
                    m_ptr += 16;
                    if (m_ptr >= (4096 << cfg[15:13])) m_ptr = 0;
                end else begin
                    q.push_back('{base, {m_c1, m_c2}});
                end
            end
        end
        m_en = en;
    endtask

    task automatic compare();
        bit ev = (q.size() != 0);
        chk(wr_valid == ev, req, "valid", 64'(wr_valid), 64'(ev));
        if (ev && wr_valid) begin
            chk(wr_addr == q[0].a, req, "addr", 64'(wr_addr), 64'(q[0].a));
            chk(wr_data == q[0].d, req, "data", wr_data, q[0].d);
        end
        chk(lost == LW'(m_lost), req, "lost", 64'(lost), 64'(m_lost));
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n, int pct, int evt_pct);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < NE; k++) evt[k] = (($urandom % 100) < evt_pct);
            pc  = {$urandom, $urandom};
            rdy = (($urandom % 100) < pct);
            cyc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(wr_valid == 0, "R1", "valid in reset", 64'(wr_valid), 0);
        chk(lost == 0, "R1", "lost in reset", 64'(lost), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_valid == 0, "R1", "valid after reset", 64'(wr_valid), 0);
        chk(lost == 0, "R1", "lost after reset", 64'(lost), 0);

        // R2: disabled block ignores strobes and overflow-ready config
        req = "R2";
        cfg = mk_cfg(2'd0, 32'hFFFF_FFFF, 7'd3, 7'd9, 3'd0);
        ctl = mk_ctl(1'b0, 1'b1, 43'h123);
        run(40, 100, 50);

        // R5: trace records on each overflow
        req = "R5";
        cfg = mk_cfg(2'd0, 32'hFFFF_FFF0, 7'd5, 7'd100, 3'd0);
        ctl = mk_ctl(1'b1, 1'b1, 43'h1234);
        run(600, 60, 30);

        // R6: run past 256 records to wrap the 4096-byte buffer
        req = "R6";
        run(4200, 80, 30);

        // R3: event-driven tick sources
        req = "R3";
        cfg = mk_cfg(2'd1, 32'hFFFF_FFFC, 7'd5, 7'd100, 3'd1);
        run(800, 70, 50);
        cfg = mk_cfg(2'd2, 32'hFFFF_FFFC, 7'd127, 7'd0, 3'd1);
        run(500, 70, 40);
        cfg = mk_cfg(2'd3, 32'hFFFF_FFFA, 7'd64, 7'd65, 3'd1);
        run(500, 70, 30);

        // R4: short reload interval
        req = "R4";
        cfg = mk_cfg(2'd0, 32'hFFFF_FFFD, 7'd1, 7'd2, 3'd2);
        run(400, 100, 50);

        // R8: heavy back-pressure
        req = "R8";
        cfg = mk_cfg(2'd0, 32'hFFFF_FFE0, 7'd1, 7'd2, 3'd0);
        run(600, 15, 50);

        // R7: accumulation mode
        req = "R7";
        ctl = mk_ctl(1'b1, 1'b0, 43'h0ABC);
        cfg = mk_cfg(2'd0, 32'hFFFF_FFE8, 7'd10, 7'd11, 3'd0);
        run(600, 60, 50);

        // R10: disable mid-record, then re-enable
        req = "R10";
        ctl = mk_ctl(1'b1, 1'b1, 43'h0777);
        cfg = mk_cfg(2'd0, 32'hFFFF_FFF0, 7'd7, 7'd8, 3'd0);
        run(100, 30, 50);
        ctl = mk_ctl(1'b0, 1'b1, 43'h0777);
        run(60, 50, 50);
        ctl = mk_ctl(1'b1, 1'b1, 43'h0777);
        run(200, 70, 50);

        // R9: overflow every cycle with a stalled record
        req = "R9";
        ctl = mk_ctl(1'b0, 1'b1, 43'h0100);
        run(5, 100, 0);
        ctl = mk_ctl(1'b1, 1'b1, 43'h0100);
        cfg = mk_cfg(2'd0, 32'hFFFF_FFFF, 7'd1, 7'd2, 3'd0);
        run(300, 0, 50);
        chk(lost == 8'hFF, "R9", "lost saturated", 64'(lost), 64'hFF);
        run(50, 100, 50);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule